// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block carries 36-bit words from a write clock domain to a read clock domain, where the two clocks may have no phase or frequency relationship. The writer sees one flag, `wr_ready`, which is high while at least one storage slot is free. A write request made while the flag is low is dropped. The reader sees `rd_valid`, which is high while the output register holds a word that has not yet been consumed.

The read side works in fall-through fashion. When the output register is empty and a word arrives, the word is moved into the register with no request from the reader. Once a word is shown, it stays in place until the reader asserts `rd_en`. On that edge the next stored word, if one exists, replaces it. If none exists, `rd_valid` drops.

Each side keeps its pointer in binary and also publishes a Gray-coded copy of it. The other domain receives that copy through a chain of flip-flops. Full and empty are decided by comparing a local Gray pointer with the synchronized Gray pointer from the far side. One active-low reset, sampled synchronously in both domains, brings the block to its empty state.

Top module: `rdyflag_fifo`

## Requirements
- R1: Two states hold while reset is low and after it is released with no traffic: `rd_valid` is low and `wr_ready` is high.
- R2: With the default two-stage synchronizer, a word written into an empty FIFO appears in `rd_data` on the third `rd_clk` rising edge after the `wr_clk` edge that stored it. `rd_valid` rises on that same edge, and no read request is needed. On the first two of those edges `rd_valid` stays low.
- R3: While `rd_valid` is low, `rd_en` has no effect. No stored word is skipped, and the next word written is still the one that appears.
- R4: While `rd_valid` is high and `rd_en` is low, `rd_valid` stays high and `rd_data` does not change.
- R5: With `rd_valid` high, a rising edge with `rd_en` high consumes the shown word. On that edge the next stored word is loaded, or `rd_valid` falls if nothing is stored.
- R6: `wr_ready` falls on the edge that accepts the write filling the last of the DEPTH memory slots. The word held in the output register does not occupy a slot, so with the reader idle, DEPTH+1 words fit in total.
- R7: A write request while `wr_ready` is low is ignored. Its data never reaches the read side.
- R8: Words leave in exactly the order in which they were accepted, whatever the ratio of the clocks and the pattern of requests on both sides. Each pointer's Gray copy changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, sampled synchronously on both clocks |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request; accepted when `wr_ready` is high |
| wr_data | input | 36 | Word to store |
| wr_ready | output | 1 | High when a storage slot is free (write clock) |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Consume the shown word; ignored while `rd_valid` is low |
| rd_data | output | 36 | Output register contents |
| rd_valid | output | 1 | High when `rd_data` holds an unread word (read clock) |

## Verification
The hardest case to reach from the ports is the full boundary. It depends on the first word having already fallen through to the output register, and on the advanced read pointer having travelled back across the synchronizer. Only then does the count DEPTH+1 hold. The stimulus therefore writes one word, waits many write cycles, and then writes until the flag drops, with extra requests carrying a marker value that must never appear at the reader. The latency check relies on clocks chosen so that no read edge ever coincides with a write edge. This lets the bench count read edges after a write without ambiguity.

// File: rtl/rdyflag_fifo_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-clock ready-flag FIFO.
// Assumes nothing beyond the standard language.
package rdyflag_fifo_pkg;
    localparam int DEF_DATA_W = 36;
    localparam int DEF_DEPTH  = 256;
    localparam int DEF_SYNC   = 2;

    // State of the read-side output register.
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_HOLD  = 1'b1
    } out_state_t;
endpackage

// File: rtl/rf_sync.sv
`timescale 1ns/1ps
// Multi-stage flip-flop chain that carries a Gray-coded pointer into
// another clock domain. Assumes at most one bit of d changes between
// samples, so a sample is always an old or a new value. STAGES >= 2.
module rf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the incoming value through the chain each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rf_mem.sv
`timescale 1ns/1ps
// Storage array: one synchronous write port, one combinational read port.
// Assumes the reader only uses rdata at addresses that have been written.
module rf_mem #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [1<<AW];

    // Write one word per accepted request.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rf_wr_ctl.sv
`timescale 1ns/1ps
// Write-side control: binary/Gray write pointer and the registered
// input-ready flag. The full test compares the next Gray pointer with the
// synchronized read pointer. Assumes AW >= 2.
module rf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rgray_sync,
    output logic        wr_ready,
    output logic        wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray
);
    logic [AW:0] wbin, wbin_nx, wgray_nx, full_pat;
    logic        full_nx;

    // Accept a write only while a slot is free.
    assign wr_fire  = wr_en && wr_ready;
    assign wbin_nx  = wbin + {{AW{1'b0}}, wr_fire};
    assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    // The write pointer is a full lap ahead when the top two Gray bits differ.
    assign full_pat = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
    assign full_nx  = (wgray_nx == full_pat);
    assign waddr    = wbin[AW-1:0];

    // Advance the pointer and refresh the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            wr_ready <= 1'b1;
        end else begin
            wbin     <= wbin_nx;
            wgray    <= wgray_nx;
            wr_ready <= !full_nx;
        end
    end

    // R7
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(wgray));
    // R8
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/rf_rd_ctl.sv
`timescale 1ns/1ps
// Read-side control: read pointer, empty test against the synchronized
// write pointer, the output-ready state machine and the output register.
// A word is loaded when storage is non-empty and either the register is
// empty or the reader consumes the shown word.
module rf_rd_ctl
    import rdyflag_fifo_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    out_state_t  state;
    logic [AW:0] rbin, rbin_nx, rgray_nx;
    logic        empty, load;

    assign empty    = (rgray == wgray_sync);
    assign load     = !empty && ((state == OUT_EMPTY) || rd_en);
    assign rbin_nx  = rbin + {{AW{1'b0}}, load};
    assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    assign raddr    = rbin[AW-1:0];
    assign rd_valid = (state == OUT_HOLD);

    // Move words into the output register and track its state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            state   <= OUT_EMPTY;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            if (load) begin
                rd_data <= mem_q;
                state   <= OUT_HOLD;
            end else if (rd_en) begin
                state   <= OUT_EMPTY;
            end
        end
    end

    // R2
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !empty) |=> rd_valid);
    // R3
    ignored_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && empty) |=> $stable(rgray));
    // R4
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
    // R5
    drain_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_en && empty) |=> !rd_valid);
    // R8
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/rdyflag_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with an input-ready flag on the write clock and a
// fall-through output-ready flag on the read clock. Gray pointers cross
// the domains through SYNC_STAGES flip-flops. DEPTH is a power of two >= 4.
module rdyflag_fifo
    import rdyflag_fifo_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int DEPTH       = DEF_DEPTH,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]     wgray, rgray, wgray_rs, rgray_ws;
    logic [AW-1:0]   waddr, raddr;
    logic [DATA_W-1:0] mem_q;
    logic            wr_fire;

    rf_mem #(.AW(AW), .DW(DATA_W)) u_mem (
        .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    rf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
        .wr_ready(wr_ready), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray)
    );

    rf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
    );

    rf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
    );

    rf_rd_ctl #(.AW(AW), .DW(DATA_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_sync(wgray_rs),
        .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/sim_rdyflag_fifo.sv
`timescale 1ns/100ps
module sim_rdyflag_fifo;
    localparam int DW = 36;
    localparam int DEPTH = 8;
    localparam logic [DW-1:0] MARK = 36'hD_EAD0_BEEF;

    logic rst_n, wr_clk, rd_clk, wr_en, rd_en, wr_ready, rd_valid;
    logic [DW-1:0] wr_data, rd_data;
    logic [DW-1:0] q[$];
    int vectors = 0;
    int errors = 0;
    int serial = 0;

    rdyflag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Write clock 250 MHz, rising at 2+4k; read clock rising at 1+6k (never coincide).
    initial begin
        wr_clk = 0; #2;
        forever begin wr_clk = 1; #2; wr_clk = 0; #2; end
    end
    initial begin
        rd_clk = 0; #1;
        forever begin rd_clk = 1; #3; rd_clk = 0; #3; end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] next_word();
        serial++;
        return {4'hA, 32'(serial)};
    endfunction

    // Store one word, waiting for a free slot; returns just after the storing edge.
    task automatic wr_one(input logic [DW-1:0] d);
        @(negedge wr_clk);
        while (!wr_ready) @(negedge wr_clk);
        wr_en = 1; wr_data = d; q.push_back(d);
        @(posedge wr_clk);
        #0.5 wr_en = 0;
    endtask

    // Read everything the model holds, checking order, then confirm the flag drops.
    task automatic drain(input string req);
        int guard = 0;
        while (q.size() > 0 && guard < 4000) begin
            @(negedge rd_clk);
            guard++;
            if (rd_valid) begin
                chk(rd_data == q[0], req, rd_data, q[0]);
                void'(q.pop_front());
                rd_en = 1;
            end else begin
                rd_en = 0;
            end
        end
        @(negedge rd_clk);
        rd_en = 0;
        chk(!rd_valid, "R5 valid falls when nothing left", {35'd0, rd_valid}, '0);
    endtask

    // Concurrent random traffic; wr_pct/rd_pct are request probabilities in percent.
    task automatic stream(input int n, input int wr_pct, input int rd_pct);
        fork
            begin
                int sent = 0;
                logic [DW-1:0] cur = next_word();
                while (sent < n) begin
                    @(negedge wr_clk);
                    wr_en = 0;
                    if (($urandom % 100) < wr_pct) begin
                        wr_en = 1; wr_data = cur;
                        if (wr_ready) begin
                            q.push_back(cur); sent++; cur = next_word();
                        end
                    end
                end
                @(negedge wr_clk) wr_en = 0;
            end
            begin
                int got = 0;
                while (got < n) begin
                    @(negedge rd_clk);
                    rd_en = 0;
                    if (rd_valid && (($urandom % 100) < rd_pct)) begin
                        if (q.size() == 0) begin
                            chk(0, "R8 word with empty model", rd_data, '0);
                        end else begin
                            chk(rd_data == q[0], "R8 order under stream", rd_data, q[0]);
                            void'(q.pop_front());
                        end
                        rd_en = 1; got++;
                    end
                end
                @(negedge rd_clk) rd_en = 0;
            end
        join
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] a;
        int cnt;
        rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
        repeat (6) @(negedge rd_clk);
        chk(!rd_valid, "R1 rd_valid low in reset", {35'd0, rd_valid}, '0);
        chk(wr_ready, "R1 wr_ready high in reset", {35'd0, wr_ready}, 36'd1);
        #0.5 rst_n = 1;
        repeat (6) @(negedge rd_clk);
        chk(!rd_valid, "R1 rd_valid low after reset", {35'd0, rd_valid}, '0);
        chk(wr_ready, "R1 wr_ready high after reset", {35'd0, wr_ready}, 36'd1);

        // R2: fall-through latency, counted in read edges after the write edge.
        a = next_word();
        wr_one(a);
        for (int i = 1; i <= 3; i++) begin
            @(posedge rd_clk);
            @(negedge rd_clk);
            if (i < 3) chk(!rd_valid, "R2 valid early", {35'd0, rd_valid}, '0);
            else chk(rd_valid && rd_data == a, "R2 word on third read edge", rd_data, a);
        end
        // R4: word held without a read request.
        for (int i = 0; i < 5; i++) begin
            @(negedge rd_clk);
            chk(rd_valid && rd_data == a, "R4 hold", rd_data, a);
        end
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        void'(q.pop_front());
        chk(!rd_valid, "R5 consume last word", {35'd0, rd_valid}, '0);

        // R3: reads while empty are ignored.
        rd_en = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge rd_clk);
            chk(!rd_valid, "R3 valid while reading empty", {35'd0, rd_valid}, '0);
        end
        rd_en = 0;
        a = next_word();
        wr_one(a);
        repeat (4) @(negedge rd_clk);
        chk(rd_valid && rd_data == a, "R3 next word not skipped", rd_data, a);
        drain("R3 drain");

        // R6/R7: fill with reader idle.
        wr_one(next_word());
        repeat (20) @(negedge wr_clk);
        cnt = 0;
        for (int i = 0; i < DEPTH + 6; i++) begin
            @(negedge wr_clk);
            wr_en = 1;
            if (wr_ready) begin
                wr_data = next_word(); q.push_back(wr_data); cnt++;
            end else begin
                wr_data = MARK;
            end
        end
        @(negedge wr_clk);
        wr_en = 0;
        chk(cnt == DEPTH, "R6 slots accepted", DW'(cnt), DW'(DEPTH));
        chk(!wr_ready, "R6 ready low when full", {35'd0, wr_ready}, '0);
        chk(q.size() == DEPTH + 1, "R6 total held", DW'(q.size()), DW'(DEPTH + 1));
        @(negedge rd_clk);
        chk(rd_valid && rd_data == q[0], "R6 first word in output", rd_data, q[0]);
        drain("R7 drain after full");
        repeat (10) @(negedge rd_clk);
        chk(!rd_valid, "R7 ignored write never shows", rd_data, MARK);
        chk(wr_ready, "R6 ready back after drain", {35'd0, wr_ready}, 36'd1);

        // R8/R5: streaming with several request densities.
        stream(300, 50, 50);
        stream(300, 95, 20);
        stream(300, 20, 95);
        stream(300, 100, 100);
        drain("R8 tail");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule